// File: doc/BRIEF.md
# Logical Shifter with Condition Flags

This block is the logical-shift slice of a DSP datapath. A 32-bit operand is moved by a signed amount: positive values move it toward the MSB, negative values toward the LSB, and the vacated positions are filled with zeros. The shifted value is available combinationally in the same cycle. The block also keeps an 8-bit status register. That register holds a decision flag whose meaning is picked at run time by a 3-bit mode field, together with sign, zero, overflow and greater-than flags.

Each operation is either unconditional or conditional. An unconditional operation refreshes the flags at the next rising clock edge. A conditional operation never touches the flags, even when its condition holds and its shifted value is used. A separate write port loads the whole status register, which is how the mode field is set. That write wins over a flag update that falls in the same cycle.

Status register layout: bit 0 decision flag (dc), bit 1 sign (n), bit 2 zero (z), bit 3 overflow (v), bit 4 greater-than (gt), bits 7:5 mode select.

Top module: `dsp_logic_shifter`

## Requirements
- R1: A positive shift amount k shifts the operand left by k places. The low k bits of `result` are zero.
- R2: A negative shift amount -k shifts the operand right by k places. The high k bits of `result` are zero. A shift of 32 (amount -32) gives zero.
- R3: A shift amount of zero passes the operand through unchanged. In mode 000 that operation sets dc to 0.
- R4: One cycle after an unconditional valid operation without a register write, n equals bit 31 of the result and z is 1 exactly when the result is zero, whatever the mode. v and gt are 0.
- R5: In mode 000, dc after an unconditional operation equals the last bit shifted out of the operand.
- R6: In mode 001, dc after an unconditional operation equals bit 31 of the result. In mode 010, dc is 1 when the result is zero and 0 otherwise.
- R7: In modes 011 through 111, dc after an unconditional operation is 0.
- R8: A conditional operation (`op_cond`=1) leaves the whole status register unchanged, whether `cond_true` is 0 or 1. No shift operation changes the mode field.
- R9: `exec` is 1 when `op_valid` is 1 and either `op_cond` is 0 or `cond_true` is 1. Otherwise it is 0.
- R10: When `sr_wr_en` is 1, the status register holds `sr_wr_data` after the clock edge, even if an unconditional operation is presented in the same cycle.
- R11: Synchronous reset sets the status register to 0.
- R12: With `op_valid` at 0 and no register write, the status register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A shift operation is presented this cycle |
| op_cond | input | 1 | 1 = conditional operation, 0 = unconditional |
| cond_true | input | 1 | Condition outcome for a conditional operation |
| operand | input | 32 | Value to shift |
| shamt | input | 6 | Signed shift amount, two's complement |
| sr_wr_en | input | 1 | Load the status register |
| sr_wr_data | input | 8 | Value loaded into the status register |
| result | output | 32 | Shifted value, combinational |
| exec | output | 1 | The operation's result is to be used |
| status | output | 8 | Status register contents |

## Verification
On every clock edge, the bound checker confirms several properties. It checks that v and gt clear after an unconditional update, that n tracks the result MSB, and that dc is zero in the constant-zero modes. It also checks that conditional or idle cycles leave the register alone, that a register write always lands, and that a zero amount passes the operand through. What the checker cannot show is the arithmetic of every shift: which bit leaves last for each amount, and the zero fill at both ends. The bench sweeps every amount from -32 to 31 in all eight modes over several operands and compares against a bit-by-bit model. Its directed scenarios cover reset, conditional operations with both condition outcomes, and a write colliding with an update.

// File: rtl/dsp_shift_pkg.sv
`timescale 1ns/1ps
package dsp_shift_pkg;

    localparam int SR_W = 8;

    typedef enum logic [2:0] {
        MODE_CARRY = 3'b000,
        MODE_NEG   = 3'b001,
        MODE_ZERO  = 3'b010,
        MODE_OVF   = 3'b011,
        MODE_SGT   = 3'b100,
        MODE_SGE   = 3'b101,
        MODE_RSV6  = 3'b110,
        MODE_RSV7  = 3'b111
    } dc_mode_e;

    typedef struct packed {
        dc_mode_e mode;
        logic     gt;
        logic     v;
        logic     z;
        logic     n;
        logic     dc;
    } status_t;

    // Decision flag as chosen by the mode field
    function automatic logic pick_dc(dc_mode_e mode, logic carry,
                                     logic msb, logic is_zero);
        logic d;
        case (mode)
            MODE_CARRY: d = carry;
            MODE_NEG:   d = msb;
            MODE_ZERO:  d = is_zero;
            default:    d = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/shift_core.sv
`timescale 1ns/1ps
module shift_core #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] shifted,
    output logic              carry_out
);
    // Right shifts reuse the left barrel on a bit-reversed operand.
    logic              go_right;
    logic [AMT_W-1:0]  mag;
    logic [DATA_W-1:0] op_rev;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] stage_v [0:AMT_W];
    logic              stage_c [0:AMT_W];
    logic [DATA_W-1:0] out_rev;

    assign go_right = amt[AMT_W-1];
    assign mag      = go_right ? (~amt + 1'b1) : amt;

    for (genvar g = 0; g < DATA_W; g++) begin : g_rev
        assign op_rev[g]  = operand[DATA_W-1-g];
        assign out_rev[g] = stage_v[AMT_W][DATA_W-1-g];
    end

    assign src        = go_right ? op_rev : operand;
    assign stage_v[0] = src;
    assign stage_c[0] = 1'b0;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int S = 1 << i;
        if (S < DATA_W) begin : g_part
            assign stage_v[i+1] = mag[i] ? (stage_v[i] << S) : stage_v[i];
            assign stage_c[i+1] = mag[i] ? stage_v[i][DATA_W-S] : stage_c[i];
        end else if (S == DATA_W) begin : g_full
            assign stage_v[i+1] = mag[i] ? '0 : stage_v[i];
            assign stage_c[i+1] = mag[i] ? stage_v[i][0] : stage_c[i];
        end else begin : g_over
            assign stage_v[i+1] = mag[i] ? '0 : stage_v[i];
            assign stage_c[i+1] = mag[i] ? 1'b0 : stage_c[i];
        end
    end

    assign shifted   = go_right ? out_rev : stage_v[AMT_W];
    assign carry_out = stage_c[AMT_W];

endmodule

// File: rtl/flag_calc.sv
`timescale 1ns/1ps
module flag_calc
    import dsp_shift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] shifted,
    input  logic              carry,
    input  dc_mode_e          mode,
    output status_t           next_flags
);
    logic msb;
    logic is_zero;

    assign msb     = shifted[DATA_W-1];
    assign is_zero = (shifted == '0);

    always_comb begin
        next_flags.mode = mode;
        next_flags.gt   = 1'b0;
        next_flags.v    = 1'b0;
        next_flags.z    = is_zero;
        next_flags.n    = msb;
        next_flags.dc   = pick_dc(mode, carry, msb, is_zero);
    end

endmodule

// File: rtl/status_reg.sv
`timescale 1ns/1ps
module status_reg
    import dsp_shift_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  status_t wr_val,
    input  logic    upd_en,
    input  status_t upd_val,
    output status_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wr_val;
        else if (upd_en)
            q <= upd_val;
    end

endmodule

// File: rtl/dsp_logic_shifter.sv
`timescale 1ns/1ps
module dsp_logic_shifter
    import dsp_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_cond,
    input  logic              cond_true,
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  shamt,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    output logic [DATA_W-1:0] result,
    output logic              exec,
    output logic [SR_W-1:0]   status
);
    logic    carry;
    status_t sr_q;
    status_t flags_nx;
    logic    flag_upd;

    shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .operand   (operand),
        .amt       (shamt),
        .shifted   (result),
        .carry_out (carry)
    );

    flag_calc #(.DATA_W(DATA_W)) u_flags (
        .shifted    (result),
        .carry      (carry),
        .mode       (sr_q.mode),
        .next_flags (flags_nx)
    );

    assign flag_upd = op_valid && !op_cond;
    assign exec     = op_valid && (!op_cond || cond_true);

    status_reg u_sr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sr_wr_en),
        .wr_val  (status_t'(sr_wr_data)),
        .upd_en  (flag_upd),
        .upd_val (flags_nx),
        .q       (sr_q)
    );

    assign status = sr_q;

endmodule

// File: rtl/dsp_logic_shifter_chk.sv
`timescale 1ns/1ps
module dsp_logic_shifter_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              op_cond,
    input logic              sr_wr_en,
    input logic [7:0]        sr_wr_data,
    input logic [DATA_W-1:0] operand,
    input logic [AMT_W-1:0]  shamt,
    input logic [DATA_W-1:0] result,
    input logic [7:0]        status
);
    // R4
    vgt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_cond && !sr_wr_en) |=> (status[3] == 1'b0 && status[4] == 1'b0));

    // R4
    n_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_cond && !sr_wr_en) |=> (status[1] == $past(result[DATA_W-1])));

    // R7
    dc_const_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_cond && !sr_wr_en && status[7:5] >= 3'd3) |=> (status[0] == 1'b0));

    // R8
    cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_cond && !sr_wr_en) |=> $stable(status));

    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        sr_wr_en |=> (status == $past(sr_wr_data)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !sr_wr_en) |=> $stable(status));

    // R3
    zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
        (shamt == '0) |-> (result == operand));

endmodule

bind dsp_logic_shifter dsp_logic_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_cond    (op_cond),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_data (sr_wr_data),
    .operand    (operand),
    .shamt      (shamt),
    .result     (result),
    .status     (status)
);

// File: tb/test_dsp_logic_shifter.sv
`timescale 1ns/1ps
module test_dsp_logic_shifter;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_cond, cond_true;
    logic [31:0] operand;
    logic [5:0]  shamt;
    logic        sr_wr_en;
    logic [7:0]  sr_wr_data;
    logic [31:0] result;
    logic        exec;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dsp_logic_shifter i_dsp_logic_shifter (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_cond(op_cond),
        .cond_true(cond_true), .operand(operand), .shamt(shamt),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .result(result), .exec(exec), .status(status)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bit-by-bit model of the shift; returns {carry, value}
    function automatic logic [32:0] model(logic [31:0] op, int amt);
        logic [31:0] r = '0;
        logic        c = 1'b0;
        int          k = (amt < 0) ? -amt : amt;
        for (int b = 0; b < 32; b++) begin
            if (amt >= 0) begin
                if (b - k >= 0) r[b] = op[b-k];
            end else begin
                if (b + k < 32) r[b] = op[b+k];
            end
        end
        if (k > 0) c = (amt > 0) ? op[32-k] : op[k-1];
        return {c, r};
    endfunction

    task automatic write_sr(logic [7:0] val);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = val;
        @(negedge clk);
        sr_wr_en = 1'b0;
        check("R10", {24'd0, status}, {24'd0, val});
    endtask

    task automatic sweep_op(logic [31:0] op, int amt, logic [2:0] mode);
        logic [32:0] m;
        logic        zr, dcx;
        logic [7:0]  exp_sr;
        m  = model(op, amt);
        zr = (m[31:0] == 32'd0);
        case (mode)
            3'd0: dcx = m[32];
            3'd1: dcx = m[31];
            3'd2: dcx = zr;
            default: dcx = 1'b0;
        endcase
        exp_sr = {mode, 1'b0, 1'b0, zr, m[31], dcx};
        @(negedge clk);
        op_valid = 1'b1; op_cond = 1'b0; cond_true = 1'b0;
        operand = op; shamt = 6'(amt);
        #1;
        if (amt > 0)      check("R1", result, m[31:0]);
        else if (amt < 0) check("R2", result, m[31:0]);
        else              check("R3", result, op);
        @(negedge clk);
        op_valid = 1'b0;
        // R4 R5 R6 R7 flag image after the update
        if (mode == 3'd0)      check("R5", {24'd0, status}, {24'd0, exp_sr});
        else if (mode <= 3'd2) check("R6", {24'd0, status}, {24'd0, exp_sr});
        else                   check("R7", {24'd0, status}, {24'd0, exp_sr});
    endtask

    initial begin
        rst = 1'b1; op_valid = 0; op_cond = 0; cond_true = 0;
        operand = '0; shamt = '0; sr_wr_en = 0; sr_wr_data = '0;
        repeat (3) @(negedge clk);
        check("R11", {24'd0, status}, 32'd0);
        rst = 1'b0;

        // Sweep every mode, amount and a few operands
        for (int md = 0; md < 8; md++) begin
            for (int oi = 0; oi < 4; oi++) begin
                logic [31:0] op;
                case (oi)
                    0: op = 32'hA5C3_0F81;
                    1: op = 32'h8000_0001;
                    2: op = 32'hFFFF_FFFF;
                    default: op = 32'h0000_0000;
                endcase
                write_sr({3'(md), 5'b11111});
                for (int a = -32; a < 32; a++) sweep_op(op, a, 3'(md));
            end
        end

        // R4: N and Z independent of mode, V and GT cleared
        write_sr({3'd5, 5'b11111});
        sweep_op(32'h4000_0000, 1, 3'd5);
        check("R4", {31'd0, status[1]}, 32'd1);
        check("R4", {30'd0, status[4:3]}, 32'd0);

        // R8 and R9: conditional operations leave the flags alone
        for (int ct = 0; ct < 2; ct++) begin
            write_sr(8'b0101_1010);
            @(negedge clk);
            op_valid = 1'b1; op_cond = 1'b1; cond_true = 1'(ct);
            operand = 32'h0000_0000; shamt = 6'd0;
            #1;
            check("R9", {31'd0, exec}, 32'(ct));
            @(negedge clk);
            op_valid = 1'b0;
            check("R8", {24'd0, status}, 32'h5A);
        end

        // R9: exec for unconditional and idle
        @(negedge clk);
        op_valid = 1'b1; op_cond = 1'b0; cond_true = 1'b0; #1;
        check("R9", {31'd0, exec}, 32'd1);
        op_valid = 1'b0; #1;
        check("R9", {31'd0, exec}, 32'd0);

        // R12: idle cycles hold the register
        write_sr(8'b1011_0110);
        operand = 32'h0; shamt = 6'd3;
        repeat (3) @(negedge clk);
        check("R12", {24'd0, status}, 32'hB6);

        // R10: write collides with an unconditional update
        @(negedge clk);
        op_valid = 1'b1; op_cond = 1'b0; operand = 32'h0; shamt = 6'd0;
        sr_wr_en = 1'b1; sr_wr_data = 8'b0011_1001;
        @(negedge clk);
        op_valid = 1'b0; sr_wr_en = 1'b0;
        check("R10", {24'd0, status}, 32'h39);

        // R11: reset clears a loaded register
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R11", {24'd0, status}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule